// File: doc/BRIEF.md
# Accumulator Memory-Reference Executor

This block carries out a single memory-reference or immediate instruction for a 16-bit accumulator machine. It holds the architectural accumulator and the one-bit link. For each instruction it receives the fetched word and the program counter value that already points past it. It returns the next program counter value, the updated accumulator and link, and the number of machine cycles the instruction costs.

Effective addresses come from an external resolver, which handles indirection. The executor sends it the 11-bit address field and the indirect bit, then waits for an acknowledge. Data words are read and written through a request/acknowledge memory port. A start/busy/done handshake runs the instructions one at a time. A start that arrives while an instruction is in progress has no effect.

The instruction word is laid out as follows. Bit 15 is the indirect flag. Bits 14..11 hold the opcode. Bits 10..0 hold the address or immediate field.

Top module: `acc_mref_exec`

## Requirements
- R1: The opcode is taken from instr[14:11] and the indirect flag from instr[15]. The opcodes are: 1 load immediate (bit 15 clear) or load complement (bit 15 set); 2 jump; 4 deposit; 5 exchange; 6 increment-and-skip-if-zero; 7 subroutine call; 13 add; 14 subtract; 15 skip-if-equal.
- R2: Load immediate sets AC to the zero-extended instr[10:0]. Load complement sets AC to the 16-bit ones' complement of that value. Both report 1 cycle, leave L unchanged, return pc_out = pc_in and make no memory access.
- R3: Jump returns pc_out = effective address. AC and L are unchanged.
- R4: Subroutine call writes the zero-extended pc_in into the effective address and returns pc_out = effective address + 1, modulo 2^ADDR_W.
- R5: Deposit writes AC to the effective address. Exchange writes AC to the effective address and loads AC with the word previously stored there.
- R6: Increment-and-skip writes (word + 1) mod 2^16 back to the same address. If the result is zero, pc_out = pc_in + 1; otherwise pc_out = pc_in.
- R7: Add and subtract keep the low 16 bits in AC. A carry out of bit 15 (add) or a borrow (subtract) inverts L.
- R8: Skip-if-equal returns pc_out = pc_in + 1 when AC equals the addressed word, and pc_in otherwise.
- R9: Memory-reference operations report 2 cycles when bit 15 is clear and 3 cycles when it is set.
- R10: Any other opcode sets illegal_op, reports 1 cycle, leaves AC and L unchanged, returns pc_out = pc_in and issues no resolver or memory request.
- R11: start is accepted only while busy is low. done is a one-cycle pulse with busy low, and the results are valid during it. A start that arrives while busy is high is ignored. Resolver and memory requests are held steady until they are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing instr |
| instr | input | 16 | Fetched instruction word |
| pc_in | input | ADDR_W | Program counter already advanced past instr |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_req | output | 1 | Effective-address request |
| res_ind | output | 1 | Indirect flag sent to the resolver |
| res_addr | output | 11 | Address field sent to the resolver |
| res_ack | input | 1 | Resolver acknowledge |
| res_ea | input | ADDR_W | Resolved effective address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| ac_out | output | 16 | Accumulator |
| link_out | output | 1 | Link bit |
| pc_out | output | ADDR_W | Next program counter |
| cycles_out | output | 2 | Cycle count of the last instruction |
| illegal_op | output | 1 | Last instruction had an unsupported opcode |

## Verification
The bench targets several corner cases:
- Add carry and subtract borrow, which must flip the link whatever its prior value. A design that sets or clears L instead shows the wrong link on the second overflow.
- Increment-and-skip on 0177777, both direct and through indirection. A missing skip or a wrong write-back shows up in pc_out and in the bench's memory model.
- A subroutine call to the last word of the address space. It must wrap pc_out to zero and store the return address. A design that adds 1 to the stored value, or forgets the mask, is caught.
- Unsupported opcodes, which must not touch AC, L or the bus.
- A start pulsed during a busy instruction. This must produce no second completion and must not corrupt the running instruction.

// File: rtl/acc_mref_pkg.sv
package acc_mref_pkg;
  localparam int WORD_W  = 16;
  localparam int FIELD_W = 11;

  // opcode values in instr[14:11]
  localparam logic [3:0] OPC_IMM  = 4'd1;
  localparam logic [3:0] OPC_JMP  = 4'd2;
  localparam logic [3:0] OPC_DEP  = 4'd4;
  localparam logic [3:0] OPC_XCH  = 4'd5;
  localparam logic [3:0] OPC_ISZ  = 4'd6;
  localparam logic [3:0] OPC_CALL = 4'd7;
  localparam logic [3:0] OPC_ADD  = 4'd13;
  localparam logic [3:0] OPC_SUB  = 4'd14;
  localparam logic [3:0] OPC_SEQ  = 4'd15;

  typedef struct packed {
    logic imm;  // no address needed
    logic bad;  // unsupported opcode
    logic rd;   // reads the operand word
    logic wr;   // writes the operand word
  } dec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RES, S_RD, S_WR, S_FIN
  } st_t;
endpackage

// File: rtl/acc_mref_decode.sv
module acc_mref_decode
  import acc_mref_pkg::*;
(
  input  logic [3:0] opc,
  output dec_t       d
);
  always_comb begin
    d = '0;
    case (opc)
      OPC_IMM:                   d.imm = 1'b1;
      OPC_JMP:                   ;
      OPC_DEP, OPC_CALL:         d.wr  = 1'b1;
      OPC_XCH, OPC_ISZ: begin
        d.rd = 1'b1;
        d.wr = 1'b1;
      end
      OPC_ADD, OPC_SUB, OPC_SEQ: d.rd  = 1'b1;
      default:                   d.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/acc_mref_alu.sv
module acc_mref_alu
  import acc_mref_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [3:0]         opc,
  input  logic               ind,
  input  logic [FIELD_W-1:0] field,
  input  logic [WORD_W-1:0]  ac,
  input  logic               link,
  input  logic [WORD_W-1:0]  mdata,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [ADDR_W-1:0]  ea,
  output logic [WORD_W-1:0]  ac_nx,
  output logic               link_nx,
  output logic [ADDR_W-1:0]  pc_nx,
  output logic [WORD_W-1:0]  wdata
);
  logic [WORD_W:0]   sum_w, dif_w;
  logic [WORD_W-1:0] inc_w, imm_w;
  logic [ADDR_W-1:0] pc_skip;

  assign sum_w   = {1'b0, ac} + {1'b0, mdata};
  assign dif_w   = {1'b0, ac} - {1'b0, mdata};
  assign inc_w   = mdata + WORD_W'(1);
  assign imm_w   = WORD_W'(field);
  assign pc_skip = pc + ADDR_W'(1);

  always_comb begin
    ac_nx   = ac;
    link_nx = link;
    pc_nx   = pc;
    wdata   = ac;
    case (opc)
      OPC_IMM:  ac_nx = ind ? ~imm_w : imm_w;
      OPC_JMP:  pc_nx = ea;
      OPC_CALL: begin
        wdata = WORD_W'(pc);
        pc_nx = ea + ADDR_W'(1);
      end
      OPC_XCH:  ac_nx = mdata;
      OPC_ISZ: begin
        wdata = inc_w;
        if (inc_w == '0) pc_nx = pc_skip;
      end
      OPC_ADD: begin
        ac_nx   = sum_w[WORD_W-1:0];
        link_nx = link ^ sum_w[WORD_W];
      end
      OPC_SUB: begin
        ac_nx   = dif_w[WORD_W-1:0];
        link_nx = link ^ dif_w[WORD_W];
      end
      OPC_SEQ:  if (ac == mdata) pc_nx = pc_skip;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_mref_ctrl.sv
module acc_mref_ctrl
  import acc_mref_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  dec_t d_in,
  input  dec_t d_q,
  input  logic res_ack,
  input  logic mem_ack,
  output logic busy,
  output logic res_req,
  output logic mem_req,
  output logic mem_we,
  output logic cap_en,
  output logic ea_en,
  output logic rd_en,
  output logic commit
);
  st_t st, nxt;

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= nxt;
  end

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (start) nxt = (d_in.imm || d_in.bad) ? S_FIN : S_RES;
      S_RES:  if (res_ack) nxt = d_q.rd ? S_RD : (d_q.wr ? S_WR : S_FIN);
      S_RD:   if (mem_ack) nxt = d_q.wr ? S_WR : S_FIN;
      S_WR:   if (mem_ack) nxt = S_FIN;
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy    = (st != S_IDLE);
  assign res_req = (st == S_RES);
  assign mem_req = (st == S_RD) || (st == S_WR);
  assign mem_we  = (st == S_WR);
  assign cap_en  = (st == S_IDLE) && start;
  assign ea_en   = (st == S_RES) && res_ack;
  assign rd_en   = (st == S_RD) && mem_ack;
  assign commit  = (st == S_FIN);
endmodule

// File: rtl/acc_mref_exec.sv
module acc_mref_exec
  import acc_mref_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [WORD_W-1:0]   instr,
  input  logic [ADDR_W-1:0]   pc_in,
  output logic                busy,
  output logic                done,
  output logic                res_req,
  output logic                res_ind,
  output logic [FIELD_W-1:0]  res_addr,
  input  logic                res_ack,
  input  logic [ADDR_W-1:0]   res_ea,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic [WORD_W-1:0]   ac_out,
  output logic                link_out,
  output logic [ADDR_W-1:0]   pc_out,
  output logic [1:0]          cycles_out,
  output logic                illegal_op
);
  localparam int OPC_LSB = FIELD_W;
  localparam int IND_BIT = WORD_W - 1;

  logic [WORD_W-1:0] instr_q, mdata_q, ac_nx, wdata;
  logic [ADDR_W-1:0] pc_q, ea_q, pc_nx;
  logic              link_nx;
  logic              cap_en, ea_en, rd_en, commit;
  dec_t              d_in, d_q;

  acc_mref_decode u_dec_in (.opc(instr[OPC_LSB +: 4]),   .d(d_in));
  acc_mref_decode u_dec_q  (.opc(instr_q[OPC_LSB +: 4]), .d(d_q));

  acc_mref_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .d_in(d_in), .d_q(d_q),
    .res_ack(res_ack), .mem_ack(mem_ack), .busy(busy),
    .res_req(res_req), .mem_req(mem_req), .mem_we(mem_we),
    .cap_en(cap_en), .ea_en(ea_en), .rd_en(rd_en), .commit(commit)
  );

  acc_mref_alu #(.ADDR_W(ADDR_W)) u_alu (
    .opc(instr_q[OPC_LSB +: 4]), .ind(instr_q[IND_BIT]),
    .field(instr_q[FIELD_W-1:0]), .ac(ac_out), .link(link_out),
    .mdata(mdata_q), .pc(pc_q), .ea(ea_q),
    .ac_nx(ac_nx), .link_nx(link_nx), .pc_nx(pc_nx), .wdata(wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q    <= '0;
      pc_q       <= '0;
      ea_q       <= '0;
      mdata_q    <= '0;
      ac_out     <= '0;
      link_out   <= 1'b0;
      pc_out     <= '0;
      cycles_out <= '0;
      illegal_op <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= commit;
      if (cap_en) begin
        instr_q <= instr;
        pc_q    <= pc_in;
      end
      if (ea_en) ea_q    <= res_ea;
      if (rd_en) mdata_q <= mem_rdata;
      if (commit) begin
        ac_out     <= ac_nx;
        link_out   <= link_nx;
        pc_out     <= pc_nx;
        illegal_op <= d_q.bad;
        if (d_q.imm || d_q.bad) cycles_out <= 2'd1;
        else                    cycles_out <= instr_q[IND_BIT] ? 2'd3 : 2'd2;
      end
    end
  end

  assign res_ind   = instr_q[IND_BIT];
  assign res_addr  = instr_q[FIELD_W-1:0];
  assign mem_addr  = ea_q;
  assign mem_wdata = wdata;
endmodule

// File: rtl/acc_mref_exec_chk.sv
module acc_mref_exec_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              res_req,
  input logic              res_ack,
  input logic [10:0]       res_addr,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       ac_out,
  input logic              link_out,
  input logic [1:0]        cycles_out,
  input logic              illegal_op
);
  // R11: completion is reported with the block idle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11: a memory request waits, unchanged, for its acknowledge
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11: a resolver request waits, unchanged, for its acknowledge
  p_res_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (res_req && !res_ack) |=> (res_req && $stable(res_addr)));

  // R11: no bus activity outside an instruction
  p_req_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req || res_req) |-> busy);

  // R2: single-cycle operations leave the link as it was
  p_one_cyc_link_r2: assert property (@(posedge clk) disable iff (rst)
    (done && cycles_out == 2'd1) |-> $stable(link_out));

  // R10: an unsupported opcode leaves the accumulator as it was
  p_bad_ac_r10: assert property (@(posedge clk) disable iff (rst)
    (done && illegal_op) |-> $stable(ac_out));
endmodule

bind acc_mref_exec acc_mref_exec_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_acc_mref_exec.sv
module sim_acc_mref_exec;
  localparam int AW = 11;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [15:0]   instr = '0;
  logic [AW-1:0] pc_in = '0;
  logic          busy, done, res_req, res_ind, res_ack = 1'b0;
  logic [10:0]   res_addr;
  logic [AW-1:0] res_ea = '0, mem_addr, pc_out;
  logic          mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0]   mem_wdata, mem_rdata = '0, ac_out;
  logic          link_out, illegal_op;
  logic [1:0]    cycles_out;

  acc_mref_exec #(.ADDR_W(AW)) u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [15:0]   ac;
    logic          lk;
    logic [AW-1:0] pc;
    logic [1:0]    cyc;
    logic          ill;
    string         tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] mem [0:(1<<AW)-1];
  int checks = 0, errors = 0, req_cnt = 0, wd = 0;

  task automatic chkv(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %o expected %o", tag, what, act, exp);
    end
  endtask

  // resolver and memory model, answering away from the active edge
  always @(negedge clk) begin
    if (res_req && !res_ack) begin
      res_ack = 1'b1;
      res_ea  = res_ind ? mem[res_addr][AW-1:0] : res_addr[AW-1:0];
      req_cnt++;
    end else res_ack = 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      mem_rdata = mem[mem_addr];
      if (mem_we) mem[mem_addr] = mem_wdata;
      req_cnt++;
    end else mem_ack = 1'b0;
  end

  // monitor: pops one expectation per completion
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected done: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chkv(e.tag, "ac", ac_out, e.ac);
        chkv(e.tag, "link", {15'd0, link_out}, {15'd0, e.lk});
        chkv(e.tag, "pc", 16'(pc_out), 16'(e.pc));
        chkv(e.tag, "cycles", {14'd0, cycles_out}, {14'd0, e.cyc});
        chkv(e.tag, "illegal", {15'd0, illegal_op}, {15'd0, e.ill});
      end
    end
  end

  task automatic issue(logic [15:0] ins, logic [AW-1:0] pc, logic [15:0] eac,
                       logic elk, logic [AW-1:0] epc, logic [1:0] ecyc,
                       logic eill, string tag, bit glitch = 0);
    exp_t e;
    while (busy) @(negedge clk);
    e.ac = eac; e.lk = elk; e.pc = epc; e.cyc = ecyc; e.ill = eill; e.tag = tag;
    sb.push_back(e);
    start = 1'b1; instr = ins; pc_in = pc;
    @(negedge clk);
    if (glitch) begin
      instr = 16'o004007;  // load immediate 7, must be ignored while busy
      @(negedge clk);
    end
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chkv("R11", "reset busy", {15'd0, busy}, 16'd0);
    chkv("R11", "reset done", {15'd0, done}, 16'd0);
    chkv("R2", "reset ac", ac_out, 16'd0);
    chkv("R7", "reset link", {15'd0, link_out}, 16'd0);

    // R1 R2: immediate forms
    issue(16'o004377, 11'o100, 16'o000377, 0, 11'o100, 1, 0, "R2 load");
    issue(16'o104001, 11'o100, 16'o177776, 0, 11'o100, 1, 0, "R2 complement");
    // R7: add without then with carry, then borrow
    mem[11'o101] = 16'o1;
    issue(16'o064101, 11'o100, 16'o177777, 0, 11'o100, 2, 0, "R7 add");
    issue(16'o064101, 11'o100, 16'o000000, 1, 11'o100, 2, 0, "R7 carry");
    // R10: unsupported opcodes keep AC=0, L=1 and stay off the bus
    req_cnt = 0;
    issue(16'o014000, 11'o100, 16'o000000, 1, 11'o100, 1, 1, "R10 opc3");
    issue(16'o060101, 11'o100, 16'o000000, 1, 11'o100, 1, 1, "R10 opc12");
    issue(16'o000000, 11'o100, 16'o000000, 1, 11'o100, 1, 1, "R10 opc0");
    chkv("R10", "bus requests", 16'(req_cnt), 16'd0);
    issue(16'o070101, 11'o100, 16'o177777, 0, 11'o100, 2, 0, "R7 borrow");
    // R5 R9: indirect deposit, exchange
    mem[11'o110] = 16'o202;
    issue(16'o120110, 11'o100, 16'o177777, 0, 11'o100, 3, 0, "R5 R9 deposit");
    chkv("R5", "deposit mem", mem[11'o202], 16'o177777);
    mem[11'o203] = 16'o012345;
    issue(16'o024203, 11'o100, 16'o012345, 0, 11'o100, 2, 0, "R5 exchange");
    chkv("R5", "exchange mem", mem[11'o203], 16'o177777);
    // R6: increment and skip
    mem[11'o204] = 16'o177777;
    issue(16'o030204, 11'o100, 16'o012345, 0, 11'o101, 2, 0, "R6 skip");
    chkv("R6", "wrap mem", mem[11'o204], 16'o0);
    mem[11'o205] = 16'o5;
    issue(16'o030205, 11'o100, 16'o012345, 0, 11'o100, 2, 0, "R6 noskip");
    chkv("R6", "inc mem", mem[11'o205], 16'o6);
    issue(16'o130110, 11'o100, 16'o012345, 0, 11'o101, 3, 0, "R6 R9 indirect");
    chkv("R6", "indirect mem", mem[11'o202], 16'o0);
    // R8: skip if equal
    issue(16'o074205, 11'o100, 16'o012345, 0, 11'o100, 2, 0, "R8 unequal");
    mem[11'o206] = 16'o012345;
    issue(16'o074206, 11'o100, 16'o012345, 0, 11'o101, 2, 0, "R8 equal");
    // R3: jumps
    issue(16'o010300, 11'o100, 16'o012345, 0, 11'o300, 2, 0, "R3 direct");
    mem[11'o111] = 16'o500;
    issue(16'o110111, 11'o100, 16'o012345, 0, 11'o500, 3, 0, "R3 R9 indirect");
    // R4: subroutine calls
    issue(16'o034400, 11'o123, 16'o012345, 0, 11'o401, 2, 0, "R4 direct");
    chkv("R4", "return word", mem[11'o400], 16'o123);
    issue(16'o134111, 11'o200, 16'o012345, 0, 11'o501, 3, 0, "R4 indirect");
    chkv("R4", "indirect return word", mem[11'o500], 16'o200);
    issue(16'o037777, 11'o100, 16'o012345, 0, 11'o000, 2, 0, "R4 wrap");
    chkv("R4", "wrap return word", mem[11'o3777], 16'o100);
    // R11: start pulsed again while busy is ignored
    issue(16'o064101, 11'o100, 16'o012346, 0, 11'o100, 2, 0, "R11 busy start", 1);
    repeat (6) @(negedge clk);
    chkv("R11", "idle after", {15'd0, busy}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule